// File: doc/BRIEF.md
# Indirect Select-Window Register Port for an Interrupt Router

This block is the register front end of an interrupt router. A bus master sees only three word locations in a 256-byte window. The first is a select register that holds an 8-bit internal index. The second is a 32-bit data window that reads or writes whichever internal register the index names. The third is a direct end-of-interrupt register. Behind the window are an identification register, a version register and a table of 64-bit routing entries. Each entry is reached as two 32-bit halves through a pair of adjacent indices.

The block stores the routing table itself and reports every table write on a write port. That report carries the entry number and the full updated entry, together with a service request for the delivery engine. It also forwards end-of-interrupt vectors on a strobe. The delivery engine owns two read-only bits in each entry: a busy flag and a remote-acknowledge flag. It drives them through per-pin inputs, and bus writes never overwrite them. When a write leaves an entry in edge mode, its remote-acknowledge flag is cleared.

Top module: `irq_regwin`

## Requirements
- R1: Only `acc_addr[7:0]` is decoded, so higher address bits are ignored. An access to the data window (offset 0x10) or the end-of-interrupt register (offset 0x40) takes effect only when `acc_size` is 4 (bytes). A window read of any other size returns 0, and a window or end-of-interrupt write of any other size changes nothing and emits nothing.
- R2: A write to offset 0x00 of any size stores `acc_wdata[7:0]` as the select index. A read of offset 0x00 returns that index in bits 7:0, with zeros above.
- R3: Window reads at index 0 and index 2 both return the stored 4-bit ID in bits 27:24. A window write at index 0 loads the ID from `acc_wdata[27:24]`. Window writes at indices 1 and 2 have no effect.
- R4: A window read at index 1 returns the parameter `VERSION` in bits 7:0 and `NPINS-1` in bits 23:16, with all other bits 0.
- R5: An index `i` with `TBL_BASE <= i < TBL_BASE+2*NPINS` selects entry `(i-TBL_BASE)>>1`. An odd `i` selects entry bits 63:32 and an even `i` selects bits 31:0. Any other index not named in R3 or R4 reads as 0 and ignores writes.
- R6: A table write keeps entry bit 12 (busy) and bit 14 (remote-acknowledge) out of the bus data. Entry bit 15 is the trigger mode, with 1 meaning level. If bit 15 of the resulting entry is 0, bit 14 becomes 0.
- R7: Each table write makes `tbl_we` and `svc_req` high for one cycle on the clock edge after the access. On that same edge `tbl_idx` gives the entry number and `tbl_entry` gives the entry's new 64-bit value. No other access raises them.
- R8: A 4-byte write to offset 0x40 pulses `eoi_valid` on the clock edge after the access, with `eoi_vector = acc_wdata[7:0]`. This happens only when `VERSION` is 0x20. With `VERSION` 0x11 the write is ignored.
- R9: Every read pulses `rd_valid` on the clock edge after the access, with `rd_data`. Reads of offsets other than 0x00 and 0x10 return 0.
- R10: Each cycle, entry bit 12 of pin `p` follows `eng_busy[p]`. `eng_rack_set[p]` sets bit 14, and `eng_rack_clr[p]` clears it; set wins if both are high. When a table write and `eng_rack_set` hit the same entry in the same cycle, bit 14 ends at 1 unless the entry ends in edge mode, in which case it ends at 0.
- R11: After reset the select index and ID are 0, and every entry holds 0x0000_0000_0001_0000 (bit 16, the mask bit, set). No output strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Bus access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address; only bits 7:0 decoded |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle) |
| rd_data | output | 32 | Read data |
| tbl_we | output | 1 | Table entry written |
| tbl_idx | output | IDX_W | Number of the written entry |
| tbl_entry | output | 64 | New value of the written entry |
| svc_req | output | 1 | Service pass request to delivery engine |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_vector | output | 8 | End-of-interrupt vector |
| eng_busy | input | NPINS | Busy flag per pin from delivery engine |
| eng_rack_set | input | NPINS | Set remote-acknowledge per pin |
| eng_rack_clr | input | NPINS | Clear remote-acknowledge per pin |

## Verification
Two things can land on the same entry in the same cycle: a bus table write and the delivery engine's remote-acknowledge set. The bench provokes this by raising `eng_rack_set` for the addressed pin during the write cycle itself, once with data that keeps the entry in level mode and once with data that turns it to edge mode. It judges the result from the `tbl_entry` value reported on the write port and from a later window read-back. Bit 14 must come out as 1 in the first case and 0 in the second. Edge cleanup therefore takes priority over the engine's set, and the engine's set takes priority over the bus data.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;

    localparam int unsigned BIT_BUSY = 12;
    localparam int unsigned BIT_RACK = 14;
    localparam int unsigned BIT_TRIG = 15;

    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;
    localparam logic [7:0] OFF_EOI = 8'h40;

    localparam logic [7:0] IDX_ID  = 8'h00;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_ARB = 8'h02;

    localparam logic [2:0]  WORD_SIZE = 3'd4;
    localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SEL,
        ACC_WIN,
        ACC_EOI
    } acc_kind_e;

endpackage

// File: rtl/irq_regwin_decode.sv
module irq_regwin_decode
    import irq_regwin_pkg::*;
#(
    parameter int unsigned NPINS    = 24,
    parameter logic [7:0]  TBL_BASE = 8'h10,
    parameter int unsigned IDX_W    = 5
) (
    input  logic [7:0]       off,
    input  logic [2:0]       size,
    input  logic [7:0]       sel,
    output acc_kind_e        kind,
    output logic             full_word,
    output logic             tbl_hit,
    output logic [IDX_W-1:0] tbl_num,
    output logic             tbl_hi
);

    localparam logic [8:0] NP9 = 9'(NPINS);

    logic [8:0] rel;
    logic [8:0] rel_entry;

    always_comb begin
        case (off)
            OFF_SEL: kind = ACC_SEL;
            OFF_WIN: kind = ACC_WIN;
            OFF_EOI: kind = ACC_EOI;
            default: kind = ACC_NONE;
        endcase
    end

    assign full_word = (size == WORD_SIZE);
    assign rel       = {1'b0, sel} - {1'b0, TBL_BASE};
    assign rel_entry = rel >> 1;
    assign tbl_hit   = (sel >= TBL_BASE) && (rel_entry < NP9);
    assign tbl_num   = rel_entry[IDX_W-1:0];
    assign tbl_hi    = sel[0];

endmodule

// File: rtl/irq_regwin_entry.sv
module irq_regwin_entry
    import irq_regwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        busy_in,
    input  logic        rack_set,
    input  logic        rack_clr,
    output logic [63:0] entry_d,
    output logic [63:0] entry_q
);

    logic rack_d;

    always_comb begin
        entry_d = entry_q;
        if (wr_en) begin
            if (wr_hi) begin
                entry_d[63:32] = wdata;
            end else begin
                entry_d[31:0] = wdata;
            end
        end
        entry_d[BIT_BUSY] = busy_in;
        rack_d = rack_set | (entry_q[BIT_RACK] & ~rack_clr);
        if (wr_en && !entry_d[BIT_TRIG]) begin
            rack_d = 1'b0;
        end
        entry_d[BIT_RACK] = rack_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= ENTRY_RST;
        end else begin
            entry_q <= entry_d;
        end
    end

endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
    import irq_regwin_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NPINS    = 24,
    parameter logic [7:0]  VERSION  = 8'h20,
    parameter logic [7:0]  TBL_BASE = 8'h10,
    localparam int unsigned IDX_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              tbl_we,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic [63:0]       tbl_entry,
    output logic              svc_req,
    output logic              eoi_valid,
    output logic [7:0]        eoi_vector,
    input  logic [NPINS-1:0]  eng_busy,
    input  logic [NPINS-1:0]  eng_rack_set,
    input  logic [NPINS-1:0]  eng_rack_clr
);

    localparam logic [31:0] VER_WORD = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};
    localparam logic        EOI_OK   = (VERSION == 8'h20);

    typedef struct packed {
        logic [7:0]       sel;
        logic [3:0]       id;
        logic             rd_valid;
        logic [31:0]      rd_data;
        logic             tbl_we;
        logic [IDX_W-1:0] tbl_idx;
        logic [63:0]      tbl_entry;
        logic             svc;
        logic             eoi_valid;
        logic [7:0]       eoi_vec;
    } state_t;

    state_t s_d, s_q;

    acc_kind_e        kind;
    logic             full_word;
    logic             tbl_hit;
    logic [IDX_W-1:0] tbl_num;
    logic             tbl_hi;
    logic             win_wr;
    logic             tbl_wr;
    logic [NPINS-1:0] ent_wr;
    logic [63:0]      ent_d [NPINS];
    logic [63:0]      ent_q [NPINS];

    logic unused_addr_hi;
    assign unused_addr_hi = ^acc_addr[ADDR_W-1:8];

    irq_regwin_decode #(
        .NPINS    (NPINS),
        .TBL_BASE (TBL_BASE),
        .IDX_W    (IDX_W)
    ) u_dec (
        .off       (acc_addr[7:0]),
        .size      (acc_size),
        .sel       (s_q.sel),
        .kind      (kind),
        .full_word (full_word),
        .tbl_hit   (tbl_hit),
        .tbl_num   (tbl_num),
        .tbl_hi    (tbl_hi)
    );

    assign win_wr = acc_valid && acc_write && (kind == ACC_WIN) && full_word;
    assign tbl_wr = win_wr && tbl_hit;

    for (genvar i = 0; i < NPINS; i++) begin : g_ent
        assign ent_wr[i] = tbl_wr && (tbl_num == IDX_W'(i));
        irq_regwin_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (ent_wr[i]),
            .wr_hi    (tbl_hi),
            .wdata    (acc_wdata),
            .busy_in  (eng_busy[i]),
            .rack_set (eng_rack_set[i]),
            .rack_clr (eng_rack_clr[i]),
            .entry_d  (ent_d[i]),
            .entry_q  (ent_q[i])
        );
    end

    always_comb begin
        s_d           = s_q;
        s_d.rd_valid  = 1'b0;
        s_d.rd_data   = '0;
        s_d.tbl_we    = 1'b0;
        s_d.svc       = 1'b0;
        s_d.eoi_valid = 1'b0;

        if (acc_valid && !acc_write) begin
            s_d.rd_valid = 1'b1;
            case (kind)
                ACC_SEL: s_d.rd_data = {24'h0, s_q.sel};
                ACC_WIN: begin
                    if (full_word) begin
                        if (s_q.sel == IDX_ID || s_q.sel == IDX_ARB) begin
                            s_d.rd_data = {4'h0, s_q.id, 24'h0};
                        end else if (s_q.sel == IDX_VER) begin
                            s_d.rd_data = VER_WORD;
                        end else if (tbl_hit) begin
                            s_d.rd_data = tbl_hi ? ent_q[tbl_num][63:32]
                                                 : ent_q[tbl_num][31:0];
                        end
                    end
                end
                default: s_d.rd_data = '0;
            endcase
        end

        if (acc_valid && acc_write) begin
            case (kind)
                ACC_SEL: s_d.sel = acc_wdata[7:0];
                ACC_WIN: begin
                    if (full_word) begin
                        if (s_q.sel == IDX_ID) begin
                            s_d.id = acc_wdata[27:24];
                        end else if (tbl_hit) begin
                            s_d.tbl_we    = 1'b1;
                            s_d.svc       = 1'b1;
                            s_d.tbl_idx   = tbl_num;
                            s_d.tbl_entry = ent_d[tbl_num];
                        end
                    end
                end
                ACC_EOI: begin
                    if (full_word && EOI_OK) begin
                        s_d.eoi_valid = 1'b1;
                        s_d.eoi_vec   = acc_wdata[7:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_valid   = s_q.rd_valid;
    assign rd_data    = s_q.rd_data;
    assign tbl_we     = s_q.tbl_we;
    assign tbl_idx    = s_q.tbl_idx;
    assign tbl_entry  = s_q.tbl_entry;
    assign svc_req    = s_q.svc;
    assign eoi_valid  = s_q.eoi_valid;
    assign eoi_vector = s_q.eoi_vec;

endmodule

// File: rtl/irq_regwin_chk.sv
module irq_regwin_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [2:0]        acc_size,
    input logic              rd_valid,
    input logic              tbl_we,
    input logic [63:0]       tbl_entry,
    input logic              svc_req,
    input logic              eoi_valid
);

    AST_WIN_WORD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> $past(acc_valid && acc_write && acc_size == 3'd4 && acc_addr[7:0] == 8'h10)); // R1

    AST_EDGE_NO_RACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && !tbl_entry[15]) |-> !tbl_entry[14]); // R6

    AST_SVC_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> $past(acc_valid && acc_write)); // R7

    AST_EOI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(acc_valid && acc_write && acc_size == 3'd4 && acc_addr[7:0] == 8'h40)); // R8

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && !acc_write)); // R9

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tbl_we, eoi_valid, rd_valid})); // R7

endmodule

bind irq_regwin irq_regwin_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .rd_valid  (rd_valid),
    .tbl_we    (tbl_we),
    .tbl_entry (tbl_entry),
    .svc_req   (svc_req),
    .eoi_valid (eoi_valid)
);

// File: tb/tb_irq_regwin.sv
`timescale 1ns/1ps
module tb_irq_regwin;

    localparam int NP = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [2:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [NP-1:0] eng_busy = '0;
    logic [NP-1:0] eng_rack_set = '0;
    logic [NP-1:0] eng_rack_clr = '0;

    logic        rd_valid, tbl_we, svc_req, eoi_valid;
    logic [31:0] rd_data;
    logic [4:0]  tbl_idx;
    logic [63:0] tbl_entry;
    logic [7:0]  eoi_vector;

    logic        rd_valid11, tbl_we11, svc_req11, eoi_valid11;
    logic [31:0] rd_data11;
    logic [4:0]  tbl_idx11;
    logic [63:0] tbl_entry11;
    logic [7:0]  eoi_vector11;

    always #2 clk = ~clk;

    irq_regwin dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_entry(tbl_entry), .svc_req(svc_req), .eoi_valid(eoi_valid),
        .eoi_vector(eoi_vector), .eng_busy(eng_busy), .eng_rack_set(eng_rack_set),
        .eng_rack_clr(eng_rack_clr)
    );

    irq_regwin #(.VERSION(8'h11)) dut11 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid11), .rd_data(rd_data11), .tbl_we(tbl_we11), .tbl_idx(tbl_idx11),
        .tbl_entry(tbl_entry11), .svc_req(svc_req11), .eoi_valid(eoi_valid11),
        .eoi_vector(eoi_vector11), .eng_busy(eng_busy), .eng_rack_set(eng_rack_set),
        .eng_rack_clr(eng_rack_clr)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [63:0] mdl [NP];
    logic [NP-1:0] pend_set = '0;

    logic        c_rv, c_we, c_svc, c_eoi, c11_eoi;
    logic [31:0] c_rd, c11_rd;
    logic [4:0]  c_idx;
    logic [63:0] c_ent;
    logic [7:0]  c_vec;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] a, input logic [2:0] sz,
                          input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_size = sz; acc_wdata = d;
        eng_rack_set = pend_set;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        eng_rack_set = '0; pend_set = '0;
        c_rv = rd_valid; c_rd = rd_data; c_we = tbl_we; c_idx = tbl_idx;
        c_ent = tbl_entry; c_svc = svc_req; c_eoi = eoi_valid; c_vec = eoi_vector;
        c11_eoi = eoi_valid11; c11_rd = rd_data11;
    endtask

    task automatic set_sel(input logic [7:0] s);
        access(1'b1, 12'h000, 3'd4, {24'h0, s});
    endtask

    function automatic logic [63:0] after_wr(input logic [63:0] old, input bit hi,
                                             input logic [31:0] d, input bit busy, input bit rset);
        logic [63:0] n;
        n = old;
        if (hi) n[63:32] = d; else n[31:0] = d;
        n[12] = busy;
        n[14] = rset | old[14];
        if (!n[15]) n[14] = 1'b0;
        return n;
    endfunction

    task automatic twr(input int e, input bit hi, input logic [31:0] d, input bit rset,
                       input string tag);
        logic [63:0] ex;
        ex = after_wr(mdl[e], hi, d, eng_busy[e], rset);
        set_sel(8'(8'h10 + 2 * e + (hi ? 1 : 0)));
        if (rset) pend_set[e] = 1'b1;
        access(1'b1, 12'h010, 3'd4, d);
        chk({tag, " R7 we"}, {63'h0, c_we}, 64'h1);
        chk({tag, " R7 svc"}, {63'h0, c_svc}, 64'h1);
        chk({tag, " R7 idx"}, {59'h0, c_idx}, 64'(e));
        chk({tag, " R6 entry"}, c_ent, ex);
        mdl[e] = ex;
    endtask

    task automatic trd(input int e, input bit hi, input string tag);
        set_sel(8'(8'h10 + 2 * e + (hi ? 1 : 0)));
        access(1'b0, 12'h010, 3'd4, 32'h0);
        chk({tag, " R5 read"}, {32'h0, c_rd}, {32'h0, hi ? mdl[e][63:32] : mdl[e][31:0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < NP; e++) mdl[e] = 64'h0000_0000_0001_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 strobes idle", {61'h0, tbl_we, eoi_valid, rd_valid}, 64'h0);

        // R11 reset values of select, ID, entries
        access(1'b0, 12'h000, 3'd4, 32'h0);
        chk("R11 sel reset", {32'h0, c_rd}, 64'h0);
        chk("R9 rd_valid", {63'h0, c_rv}, 64'h1);
        access(1'b0, 12'h010, 3'd4, 32'h0);
        chk("R11 id reset", {32'h0, c_rd}, 64'h0);
        for (int e = 0; e < NP; e++) begin
            trd(e, 1'b0, "R11 entry lo");
            trd(e, 1'b1, "R11 entry hi");
        end

        // R2 select register, byte write, readback
        access(1'b1, 12'h000, 3'd1, 32'hFFFF_FF5A);
        access(1'b0, 12'h000, 3'd4, 32'h0);
        chk("R2 sel readback", {32'h0, c_rd}, 64'h5A);
        // R1 upper address bits ignored
        access(1'b1, 12'hF00, 3'd4, 32'h0000_0013);
        access(1'b0, 12'h700, 3'd2, 32'h0);
        chk("R1 high addr sel", {32'h0, c_rd}, 64'h13);

        // R3 ID / arbitration
        set_sel(8'h00);
        access(1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF);
        access(1'b0, 12'h010, 3'd4, 32'h0);
        chk("R3 id read", {32'h0, c_rd}, 64'h0F00_0000);
        set_sel(8'h02);
        access(1'b0, 12'h010, 3'd4, 32'h0);
        chk("R3 arb read", {32'h0, c_rd}, 64'h0F00_0000);
        access(1'b1, 12'h010, 3'd4, 32'h0000_0000);
        set_sel(8'h00);
        access(1'b0, 12'h010, 3'd4, 32'h0);
        chk("R3 arb write ignored", {32'h0, c_rd}, 64'h0F00_0000);
        access(1'b1, 12'h010, 3'd2, 32'h0000_0000);
        access(1'b0, 12'h010, 3'd4, 32'h0);
        chk("R1 short id write ignored", {32'h0, c_rd}, 64'h0F00_0000);

        // R4 version
        set_sel(8'h01);
        access(1'b1, 12'h010, 3'd4, 32'h0);
        access(1'b0, 12'h010, 3'd4, 32'h0);
        chk("R4 version 0x20", {32'h0, c_rd}, 64'h0017_0020);
        chk("R4 version 0x11", {32'h0, c11_rd}, 64'h0017_0011);
        set_sel(8'h00);
        access(1'b0, 12'h010, 3'd4, 32'h0);
        chk("R4 ver write left id", {32'h0, c_rd}, 64'h0F00_0000);

        // R5/R6/R7 sweep every entry, both halves
        for (int e = 0; e < NP; e++) begin
            logic [31:0] lo, hi;
            lo = 32'h0001_5000 | (32'(e & 1) << 15) | (32'(e & 7) << 8) | (32'h20 + 32'(e));
            hi = (32'(e) * 32'h0101_0101) ^ 32'hC300_0000;
            twr(e, 1'b0, lo, 1'b0, "R5 sweep lo");
            twr(e, 1'b1, hi, 1'b0, "R5 sweep hi");
        end
        for (int e = 0; e < NP; e++) begin
            trd(e, 1'b0, "R5 sweep readback lo");
            trd(e, 1'b1, "R5 sweep readback hi");
        end

        // R5 out-of-range and gap indices
        set_sel(8'h40);
        access(1'b0, 12'h010, 3'd4, 32'h0);
        chk("R5 out of range read", {32'h0, c_rd}, 64'h0);
        access(1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF);
        chk("R5 out of range write", {63'h0, c_we}, 64'h0);
        set_sel(8'h0F);
        access(1'b0, 12'h010, 3'd4, 32'h0);
        chk("R5 gap index read", {32'h0, c_rd}, 64'h0);

        // R1 short window accesses
        set_sel(8'h10);
        access(1'b1, 12'h010, 3'd2, 32'h0000_0000);
        chk("R1 short write no we", {63'h0, c_we}, 64'h0);
        access(1'b0, 12'h010, 3'd1, 32'h0);
        chk("R1 short read zero", {32'h0, c_rd}, 64'h0);
        trd(0, 1'b0, "R1 entry untouched");

        // R10 engine remote-ack set, then R6 preservation on level write
        @(negedge clk); eng_rack_set[3] = 1'b1;
        @(negedge clk); eng_rack_set[3] = 1'b0;
        mdl[3][14] = 1'b1;
        trd(3, 1'b0, "R10 rack set");
        twr(3, 1'b0, 32'h0001_8033, 1'b0, "R6 level keeps rack");
        chk("R6 rack kept", {63'h0, mdl[3][14]}, 64'h1);
        twr(3, 1'b1, 32'h1234_5678, 1'b0, "R6 hi write keeps rack");
        // R10 busy mirror, R6 busy not writable
        @(negedge clk); eng_busy[3] = 1'b1;
        @(negedge clk);
        mdl[3][12] = 1'b1;
        trd(3, 1'b0, "R10 busy mirrored");
        twr(3, 1'b0, 32'h0000_8033, 1'b0, "R6 busy kept");
        eng_busy[3] = 1'b0;
        @(negedge clk); @(negedge clk);
        mdl[3][12] = 1'b0;
        // R6 edge write clears rack
        twr(3, 1'b0, 32'h0000_4033, 1'b0, "R6 edge clears rack");
        chk("R6 rack cleared", {63'h0, c_ent[14]}, 64'h0);
        trd(3, 1'b0, "R6 edge readback");

        // R10 engine clear
        @(negedge clk); eng_rack_set[5] = 1'b1;
        @(negedge clk); eng_rack_set[5] = 1'b0; eng_rack_clr[5] = 1'b1;
        @(negedge clk); eng_rack_clr[5] = 1'b0;
        trd(5, 1'b0, "R10 rack clr");
        // R10 set wins over clr
        @(negedge clk); eng_rack_set[5] = 1'b1; eng_rack_clr[5] = 1'b1;
        @(negedge clk); eng_rack_set[5] = 1'b0; eng_rack_clr[5] = 1'b0;
        mdl[5][14] = 1'b1;
        trd(5, 1'b0, "R10 set wins");

        // R10 same-cycle write and engine set
        twr(7, 1'b0, 32'h0000_8047, 1'b1, "R10 collide level");
        chk("R10 collide level rack", {63'h0, c_ent[14]}, 64'h1);
        trd(7, 1'b0, "R10 collide level readback");
        twr(9, 1'b0, 32'h0000_0049, 1'b1, "R10 collide edge");
        chk("R10 collide edge rack", {63'h0, c_ent[14]}, 64'h0);
        trd(9, 1'b0, "R10 collide edge readback");

        // R8 end-of-interrupt
        access(1'b1, 12'h040, 3'd4, 32'h1234_569C);
        chk("R8 eoi strobe", {63'h0, c_eoi}, 64'h1);
        chk("R8 eoi vector", {56'h0, c_vec}, 64'h9C);
        chk("R8 eoi gated by version", {63'h0, c11_eoi}, 64'h0);
        chk("R8 eoi no table write", {63'h0, c_we}, 64'h0);
        access(1'b1, 12'h340, 3'd4, 32'h0000_0031);
        chk("R1 eoi high addr", {56'h0, c_vec}, 64'h31);
        access(1'b1, 12'h040, 3'd2, 32'h0000_0077);
        chk("R1 short eoi ignored", {63'h0, c_eoi}, 64'h0);

        // R9 unmapped offsets
        access(1'b0, 12'h020, 3'd4, 32'h0);
        chk("R9 unmapped read", {32'h0, c_rd}, 64'h0);
        chk("R9 unmapped rd_valid", {63'h0, c_rv}, 64'h1);
        access(1'b0, 12'h040, 3'd4, 32'h0);
        chk("R9 eoi offset read", {32'h0, c_rd}, 64'h0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule